// File: doc/BRIEF.md
# Wraparound Layer Address Generator

This block turns a raster scan of one display layer into a stream of linear byte addresses in graphics memory. The layer's image lives in a logical two-dimensional space. That space starts at a base address and has a line pitch that is a whole number of 64-byte units. It also has a height counted in rows. The visible window may start anywhere inside that space, and the space is treated as a torus. When the scan runs past the right edge, it continues from the left edge of the same row. When it runs past the bottom row, it continues from the top row.

Configuration is captured once per frame on a frame-start pulse, so software can rewrite the inputs at any time without disturbing a frame in progress. The first line of a frame begins right after the frame-start pulse. Each later line begins on a line-start pulse. Each pixel-enable pulse consumes the address currently shown and steps to the next pixel. Addresses are formed incrementally, with adders only. The one multiply is done at frame start, to place the first row.

Top module: `layer_addr_gen`

## Requirements
- R1: After reset `pix_addr` is 0 and `cfg_err` is 0.
- R2: In the cycle after a `frame_start` pulse, `pix_addr` equals origin + DX·B + 64·W·DY modulo 2^ADDR_W. Here B is the bytes per pixel: 1 when `cfg_bpp16`=0 (8 bpp) and 2 when `cfg_bpp16`=1 (16 bpp).
- R3: Each `pix_en` pulse (with no frame or line start in that cycle) advances `pix_addr` by B bytes within the row.
- R4: When the next pixel offset would reach 64·W bytes, the address returns to the start of the current row.
- R5: A `line_start` pulse moves to the next row, at column DX, with the row base advanced by 64·W bytes.
- R6: After row H−1 the next row is row 0, with its base equal to the origin.
- R7: If DX·B ≥ 64·W, or if DY ≥ H, then `cfg_err` reads 1 in the cycle after `frame_start` and the offending coordinate is treated as 0. Otherwise `cfg_err` reads 0. `cfg_err` changes only after a frame start.
- R8: Changes on the configuration inputs between frame starts have no effect on the address sequence.
- R9: Address arithmetic wraps modulo 2^ADDR_W.
- R10: With no `frame_start`, `line_start` or `pix_en`, `pix_addr` holds its value.
- R11: `frame_start` takes priority over `line_start` and `pix_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_origin | input | ADDR_W | Byte address of logical point (0,0) |
| cfg_width | input | WUNIT_W | Logical line pitch in 64-byte units (W) |
| cfg_height | input | HGT_W | Logical height in rows (H) |
| cfg_bpp16 | input | 1 | 1 = 16 bits per pixel, 0 = 8 bits per pixel |
| cfg_dx | input | WUNIT_W+6 | Window origin column in pixels (DX) |
| cfg_dy | input | HGT_W | Window origin row (DY) |
| frame_start | input | 1 | Latch configuration and go to the first pixel |
| line_start | input | 1 | Move to the first pixel of the next line |
| pix_en | input | 1 | Consume the current address and step one pixel |
| pix_addr | output | ADDR_W | Byte address of the current pixel |
| cfg_err | output | 1 | Origin coordinate out of range in the latched frame |

## Verification
The bench uses the default widths: 24-bit addresses, a 6-bit pitch in 64-byte units, and an 11-bit height. It programs small logical spaces, one to three units wide and one to six rows tall, so that a single frame can run many times across both wrap points. The frames use both pixel depths and random line lengths. Directed frames cover an out-of-range DX and an out-of-range DY, and an origin near the top of the address space that exercises the modulo-2^24 wrap. Each frame also rewrites the configuration inputs partway through.

// File: rtl/layer_addr_gen.sv
module layer_addr_gen #(
  parameter int ADDR_W  = 24,
  parameter int WUNIT_W = 6,
  parameter int HGT_W   = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_origin,
  input  logic [WUNIT_W-1:0]   cfg_width,
  input  logic [HGT_W-1:0]     cfg_height,
  input  logic                 cfg_bpp16,
  input  logic [WUNIT_W+5:0]   cfg_dx,
  input  logic [HGT_W-1:0]     cfg_dy,
  input  logic                 frame_start,
  input  logic                 line_start,
  input  logic                 pix_en,
  output logic [ADDR_W-1:0]    pix_addr,
  output logic                 cfg_err
);
  localparam int PITCH_W = WUNIT_W + 6;
  localparam int PROD_W  = PITCH_W + HGT_W;

  logic [ADDR_W-1:0]  org_q, base_q;
  logic [WUNIT_W-1:0] w_q;
  logic [HGT_W-1:0]   h_q, row_q;
  logic               bpp16_q;
  logic [PITCH_W-1:0] sx_q, xoff_q;

  logic [PITCH_W-1:0] pitch_in, pitch_q;
  logic [PITCH_W:0]   dxb_in, xnext;
  logic               dx_bad, dy_bad, x_wrap, y_wrap;
  logic [HGT_W-1:0]   dy_use, row_next;
  logic [PROD_W-1:0]  dy_prod;
  logic [PITCH_W-1:0] step;

  assign pitch_in = {cfg_width, 6'b0};
  assign dxb_in   = cfg_bpp16 ? {cfg_dx, 1'b0} : {1'b0, cfg_dx};
  assign dx_bad   = dxb_in >= {1'b0, pitch_in};
  assign dy_bad   = cfg_dy >= cfg_height;
  assign dy_use   = dy_bad ? '0 : cfg_dy;
  assign dy_prod  = PROD_W'(pitch_in) * PROD_W'(dy_use);

  assign pitch_q  = {w_q, 6'b0};
  assign step     = bpp16_q ? PITCH_W'(2) : PITCH_W'(1);
  assign xnext    = {1'b0, xoff_q} + {1'b0, step};
  assign x_wrap   = xnext >= {1'b0, pitch_q};
  assign row_next = row_q + 1'b1;
  assign y_wrap   = (row_next >= h_q) || (row_next == '0);

  assign pix_addr = base_q + ADDR_W'(xoff_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      org_q   <= '0;
      base_q  <= '0;
      w_q     <= '0;
      h_q     <= '0;
      row_q   <= '0;
      bpp16_q <= 1'b0;
      sx_q    <= '0;
      xoff_q  <= '0;
      cfg_err <= 1'b0;
    end else if (frame_start) begin
      org_q   <= cfg_origin;
      w_q     <= cfg_width;
      h_q     <= cfg_height;
      bpp16_q <= cfg_bpp16;
      row_q   <= dy_use;
      base_q  <= cfg_origin + ADDR_W'(dy_prod);
      sx_q    <= dx_bad ? '0 : dxb_in[PITCH_W-1:0];
      xoff_q  <= dx_bad ? '0 : dxb_in[PITCH_W-1:0];
      cfg_err <= dx_bad | dy_bad;
    end else if (line_start) begin
      xoff_q  <= sx_q;
      row_q   <= y_wrap ? '0 : row_next;
      base_q  <= y_wrap ? org_q : base_q + ADDR_W'(pitch_q);
    end else if (pix_en) begin
      xoff_q  <= x_wrap ? '0 : xnext[PITCH_W-1:0];
    end
  end
endmodule

// File: rtl/layer_addr_gen_chk.sv
module layer_addr_gen_chk #(
  parameter int ADDR_W  = 24,
  parameter int PITCH_W = 12,
  parameter int HGT_W   = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               line_start,
  input logic               pix_en,
  input logic [ADDR_W-1:0]  pix_addr,
  input logic               cfg_err,
  input logic [ADDR_W-1:0]  base_q,
  input logic [PITCH_W-1:0] xoff_q,
  input logic [PITCH_W-1:0] pitch_q,
  input logic [PITCH_W-1:0] step,
  input logic [HGT_W-1:0]   row_q,
  input logic [HGT_W-1:0]   h_q
);
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !frame_start && !line_start) |=>
      (pix_addr == $past(pix_addr) + ADDR_W'($past(step))) || (pix_addr == base_q)); // R3
  AST_XOFF_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (pitch_q != '0) |-> (xoff_q < pitch_q)); // R4
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_q != '0) |-> (row_q < h_q)); // R6
  AST_ERR_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cfg_err)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_start && !pix_en) |=> $stable(pix_addr)); // R10
endmodule

bind layer_addr_gen layer_addr_gen_chk #(
  .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .HGT_W(HGT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .pix_en(pix_en), .pix_addr(pix_addr), .cfg_err(cfg_err), .base_q(base_q),
  .xoff_q(xoff_q), .pitch_q(pitch_q), .step(step), .row_q(row_q), .h_q(h_q)
);

// File: tb/layer_addr_gen_test.sv
`timescale 1ns/1ps
module layer_addr_gen_test;
  logic        clk = 0, rst_n = 0;
  logic [23:0] cfg_origin = 0;
  logic [5:0]  cfg_width = 0;
  logic [10:0] cfg_height = 0;
  logic        cfg_bpp16 = 0;
  logic [11:0] cfg_dx = 0;
  logic [10:0] cfg_dy = 0;
  logic        frame_start = 0, line_start = 0, pix_en = 0;
  logic [23:0] pix_addr;
  logic        cfg_err;

  int checks = 0, errors = 0;
  int m_org, m_w, m_h, m_b, m_pw, m_x, m_x0, m_y;

  layer_addr_gen uut (.*);

  always #10 clk = ~clk;

  function automatic logic [23:0] exp_addr(int org, int w, int b, int x, int y);
    return 24'(org + x * b + 64 * w * y);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_frame(int org, int w, int h, int b16, int dx, int dy, string req);
    int e;
    @(negedge clk);
    cfg_origin = 24'(org); cfg_width = 6'(w); cfg_height = 11'(h);
    cfg_bpp16 = b16[0]; cfg_dx = 12'(dx); cfg_dy = 11'(dy);
    frame_start = 1; line_start = $urandom_range(0, 1) != 0; pix_en = $urandom_range(0, 1) != 0; // R11
    m_org = org; m_w = w; m_h = h; m_b = b16 ? 2 : 1; m_pw = (64 * w) / m_b;
    e = 0;
    m_x0 = dx; m_y = dy;
    if (dx >= m_pw) begin m_x0 = 0; e = 1; end
    if (dy >= h) begin m_y = 0; e = 1; end
    m_x = m_x0;
    @(negedge clk);
    frame_start = 0; line_start = 0; pix_en = 0;
    check({req, " R7 err"}, 32'(cfg_err), 32'(e));
    check({req, " R2 first"}, 32'(pix_addr), 32'(exp_addr(m_org, m_w, m_b, m_x, m_y)));
    cfg_origin = 24'($urandom); cfg_width = 6'($urandom); cfg_height = 11'($urandom); // R8
    cfg_bpp16 = 1'($urandom); cfg_dx = 12'($urandom); cfg_dy = 11'($urandom);
  endtask

  task automatic pixel(string req);
    check(req, 32'(pix_addr), 32'(exp_addr(m_org, m_w, m_b, m_x, m_y)));
    pix_en = 1;
    @(negedge clk);
    pix_en = 0;
    m_x = (m_x + 1) % m_pw;
  endtask

  task automatic new_line();
    line_start = 1;
    @(negedge clk);
    line_start = 0;
    m_x = m_x0; m_y = (m_y + 1) % m_h;
    check("R5 line start", 32'(pix_addr), 32'(exp_addr(m_org, m_w, m_b, m_x, m_y)));
  endtask

  task automatic run_lines(int nlines, int len, string req);
    for (int l = 0; l < nlines; l++) begin
      for (int p = 0; p < len; p++) pixel(req);
      repeat (2) @(negedge clk);
      check("R10 idle hold", 32'(pix_addr), 32'(exp_addr(m_org, m_w, m_b, m_x, m_y)));
      new_line();
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset addr", 32'(pix_addr), 32'h0);
    check("R1 reset err", 32'(cfg_err), 32'h0);
    rst_n = 1;

    start_frame(24'h001000, 1, 3, 0, 60, 2, "dir8");
    run_lines(4, 70, "R4 8bpp wrap");
    start_frame(24'h002000, 2, 2, 1, 63, 1, "dir16");
    run_lines(3, 66, "R3 16bpp step");
    start_frame(24'h003000, 1, 2, 1, 32, 1, "dxbad");
    run_lines(2, 5, "R7 dx clamp");
    start_frame(24'h003000, 1, 2, 0, 5, 2, "dybad");
    run_lines(2, 5, "R7 dy clamp");
    start_frame(24'hFFFF80, 3, 5, 1, 90, 4, "top");
    run_lines(3, 20, "R9 addr wrap");
    start_frame(24'h004000, 1, 1, 0, 0, 0, "oneRow");
    run_lines(3, 3, "R6 single row");

    for (int f = 0; f < 25; f++) begin
      int w, h, b16, pw;
      w = $urandom_range(1, 3); h = $urandom_range(1, 6); b16 = $urandom_range(0, 1);
      pw = (64 * w) / (b16 ? 2 : 1);
      start_frame(int'($urandom), w, h, b16, $urandom_range(0, pw - 1),
                  $urandom_range(0, h - 1), "rnd");
      run_lines($urandom_range(1, 2 * h + 1), $urandom_range(1, 2 * pw), "R6 R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule